// File: doc/BRIEF.md
# Reusable Hardware Barrier for Multiple Processors

This block makes a group of processors meet before any of them continues. Each participating processor raises a request to enter the barrier and then waits. The unit counts entries in a gathering phase. Once the configured number of participants has entered, it switches to a release phase and grants each entered processor a permit to leave.

Every accepted exit lowers the shared count. The exit that brings the count back to zero returns the unit to the gathering phase. Because entry and exit are two separate gates around one up/down counter, a processor that loops back quickly cannot slip into the next round while others are still leaving. Its new entry request simply waits until the round has fully drained. The barrier can therefore be reused back to back.

Entry and exit use request/acknowledge handshakes. A processor raises `enter_req[i]` and holds it until `enter_ack[i]` is high in a cycle. That cycle is the transfer, and the processor lowers the request on the following edge. The same rule applies to `leave_req[i]` and `leave_done[i]`. The unit applies back-pressure by withholding the acknowledge, for as long as it likes. Requests that are not eligible stay pending or are ignored, and they never change state.

Top module: `barrier_sync`

## Requirements
- R1: After reset the count is zero, the unit is in the gathering phase, `leave_ok` is all zero and no acknowledge is given while no request is raised.
- R2: At most one transfer (entry or exit) is accepted per cycle. Among simultaneous eligible requesters the lowest processor index wins.
- R3: An entry is accepted only in the gathering phase and only from a processor that has not yet entered this round. A repeated entry request from a processor already counted is ignored.
- R4: `leave_ok` stays all zero until `part_count` entries have been accepted. From the cycle after the last of those entries, `leave_ok[i]` is 1 exactly for the processors that entered. The count never exceeds `part_count`.
- R5: An exit is accepted only from a processor whose `leave_ok` bit is 1. It is signalled by a one-cycle `leave_done[i]`, and that processor's `leave_ok` bit is 0 from the next cycle.
- R6: An entry request raised during the release phase receives no acknowledge until the last exit of the round has been accepted. It can be accepted in the cycle right after that exit.
- R7: Exit requests in the gathering phase, or from a processor that did not enter this round, are ignored: no `leave_done` is given and `leave_ok` is unchanged.
- R8: After the last exit, the count is zero and `leave_ok` is all zero. A new round with a different participant set then proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| part_count | input | CW | Number of participants per round, 1..NPROC |
| enter_req | input | NPROC | Per-processor entry request, held until acknowledged |
| enter_ack | output | NPROC | Per-processor entry acknowledge, one cycle |
| leave_req | input | NPROC | Per-processor exit request, held until done |
| leave_ok | output | NPROC | Per-processor permit to pass the barrier |
| leave_done | output | NPROC | Per-processor exit accepted, one cycle |

## Verification
The assertions assume two things about the inputs:
- `part_count` lies between 1 and NPROC and changes only while the count is zero in the gathering phase.
- Each processor holds a request until its acknowledge and drops it on the next edge.

The bench follows both rules:
- It changes `part_count` only between rounds, after all exits have drained.
- A per-processor responder lowers a request right after its acknowledge. When a rejoin mode is set, that responder raises the next entry immediately after an exit, which stresses the hold-off behaviour.
- Deliberately ineligible requests, repeated entries and exits from outsiders, are driven only where their required outcome is to be ignored.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  typedef enum logic {
    PH_GATHER  = 1'b0,
    PH_RELEASE = 1'b1
  } phase_t;
endpackage

// File: rtl/barrier_pick.sv
// Fixed-priority picker: the lowest set request bit wins.
module barrier_pick #(
  parameter int W = 4
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] gnt,
  output logic         any
);
  always_comb begin
    gnt = req & (~req + W'(1));
    any = |req;
  end
endmodule

// File: rtl/barrier_roster.sv
// Records which processors have entered in the current round.
module barrier_roster #(
  parameter int NPROC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] add,
  input  logic [NPROC-1:0] drop,
  output logic [NPROC-1:0] present
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present <= '0;
    else        present <= (present | add) & ~drop;
  end
endmodule

// File: rtl/barrier_ctrl.sv
// Shared up/down count and phase: entries count up, exits count down.
module barrier_ctrl
  import barrier_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] part_count,
  input  logic          inc,
  input  logic          dec,
  output phase_t        phase,
  output logic [CW-1:0] cnt
);
  logic [CW:0] cnt_up;

  always_comb cnt_up = {1'b0, cnt} + (CW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_GATHER;
      cnt   <= '0;
    end else if (inc) begin
      cnt <= cnt_up[CW-1:0];
      if (cnt_up >= {1'b0, part_count}) phase <= PH_RELEASE;
    end else if (dec) begin
      cnt <= cnt - CW'(1);
      if (cnt == CW'(1)) phase <= PH_GATHER;
    end
  end
endmodule

// File: rtl/barrier_sync.sv
module barrier_sync
  import barrier_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int CW    = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    part_count,
  input  logic [NPROC-1:0] enter_req,
  output logic [NPROC-1:0] enter_ack,
  input  logic [NPROC-1:0] leave_req,
  output logic [NPROC-1:0] leave_ok,
  output logic [NPROC-1:0] leave_done
);
  phase_t           phase;
  logic [CW-1:0]    cnt_q;
  logic [NPROC-1:0] present;
  logic [NPROC-1:0] enter_elig, leave_elig;
  logic [NPROC-1:0] enter_gnt, leave_gnt;
  logic             enter_any, leave_any;

  always_comb begin
    enter_elig = enter_req & ~present & {NPROC{phase == PH_GATHER}};
    leave_elig = leave_req & present & {NPROC{phase == PH_RELEASE}};
    enter_ack  = enter_gnt;
    leave_done = leave_gnt;
    leave_ok   = present & {NPROC{phase == PH_RELEASE}};
  end

  barrier_pick #(.W(NPROC)) u_enter_pick (
    .req(enter_elig), .gnt(enter_gnt), .any(enter_any)
  );

  barrier_pick #(.W(NPROC)) u_leave_pick (
    .req(leave_elig), .gnt(leave_gnt), .any(leave_any)
  );

  barrier_roster #(.NPROC(NPROC)) u_roster (
    .clk(clk), .rst_n(rst_n), .add(enter_gnt), .drop(leave_gnt), .present(present)
  );

  barrier_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .part_count(part_count),
    .inc(enter_any), .dec(leave_any), .phase(phase), .cnt(cnt_q)
  );
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
  parameter int NPROC = 4,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CW-1:0]    part_count,
  input logic [NPROC-1:0] enter_req,
  input logic [NPROC-1:0] enter_ack,
  input logic [NPROC-1:0] leave_ok,
  input logic [NPROC-1:0] leave_done,
  input logic [CW-1:0]    cnt
);
  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enter_ack, leave_done}));

  p_ack_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_ack & ~enter_req) == '0);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= part_count);

  p_permit_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_done != '0) |=> ((leave_ok & $past(leave_done)) == '0));

  p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_ack != '0) |-> (leave_ok == '0));

  p_reopen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (leave_done != '0 && $countones(leave_ok) == 1) |=> (cnt == '0 && leave_ok == '0));
endmodule

bind barrier_sync barrier_sync_chk #(.NPROC(NPROC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .part_count(part_count), .enter_req(enter_req),
  .enter_ack(enter_ack), .leave_ok(leave_ok), .leave_done(leave_done), .cnt(cnt_q)
);

// File: tb/test_barrier_sync.sv
module test_barrier_sync;
  localparam int NPROC = 4;
  localparam int CW    = $clog2(NPROC + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CW-1:0]    part_count = CW'(NPROC);
  logic [NPROC-1:0] enter_req = '0;
  logic [NPROC-1:0] leave_req = '0;
  logic [NPROC-1:0] enter_ack, leave_ok, leave_done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit rejoin = 1'b0;
  logic [NPROC-1:0] seen_ent = '0, seen_lv = '0;
  int    q_code[$];
  string q_tag[$];

  always #4 clk = ~clk;

  barrier_sync #(.NPROC(NPROC)) i_barrier_sync (
    .clk(clk), .rst_n(rst_n), .part_count(part_count),
    .enter_req(enter_req), .enter_ack(enter_ack),
    .leave_req(leave_req), .leave_ok(leave_ok), .leave_done(leave_done)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      summary();
    end
  end

  // driver side: expected transfers, kind 0 = entry, 1 = exit
  task automatic expect_xfer(int kind, int idx, string tag);
    q_code.push_back(kind * 16 + idx);
    q_tag.push_back(tag);
  endtask

  task automatic got(int kind, int idx);
    int exp;
    string tag;
    checks++;
    if (q_code.size() == 0) begin
      errors++;
      $display("FAIL R3/R7 unexpected transfer: actual kind %0d idx %0d expected none", kind, idx);
    end else begin
      exp = q_code.pop_front();
      tag = q_tag.pop_front();
      if (exp != kind * 16 + idx) begin
        errors++;
        $display("FAIL %s transfer order: actual kind %0d idx %0d expected kind %0d idx %0d",
                 tag, kind, idx, exp / 16, exp % 16);
      end
    end
  endtask

  // monitor: samples combinational acknowledges away from the edge
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones({enter_ack, leave_done}) > 1) begin
        checks++; errors++;
        $display("FAIL R2 more than one transfer: actual %b %b expected at most one",
                 enter_ack, leave_done);
      end
      for (int i = 0; i < NPROC; i++) begin
        if (enter_ack[i])  got(0, i);
        if (leave_done[i]) got(1, i);
      end
      seen_ent <= enter_ack;
      seen_lv  <= leave_done;
    end
  end

  // processor responders: drop request after acknowledge, optionally rejoin
  always @(posedge clk) begin
    #1;
    for (int i = 0; i < NPROC; i++) begin
      if (seen_ent[i]) enter_req[i] = 1'b0;
      if (seen_lv[i]) begin
        leave_req[i] = 1'b0;
        if (rejoin) enter_req[i] = 1'b1;
      end
    end
  end

  task automatic at_drive();
    @(posedge clk); #2;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (q_code.size() > 0 && guard < 200) begin
      @(posedge clk);
      guard++;
    end
    checks++;
    if (q_code.size() != 0) begin
      errors++;
      $display("FAIL %s missing transfer: actual %0d pending expected 0", q_tag[0], q_code.size());
      q_code.delete();
      q_tag.delete();
    end
  endtask

  task automatic check_ok(logic [NPROC-1:0] exp, string tag);
    @(negedge clk); #2;
    checks++;
    if (leave_ok !== exp) begin
      errors++;
      $display("FAIL %s leave_ok: actual %b expected %b", tag, leave_ok, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check_ok('0, "R1");
    checks++;
    if (enter_ack !== '0 || leave_done !== '0) begin
      errors++;
      $display("FAIL R1 idle acks: actual %b %b expected 0000 0000", enter_ack, leave_done);
    end

    // round 1: all four enter together, priority order
    for (int i = 0; i < NPROC; i++) expect_xfer(0, i, "R2");
    at_drive(); enter_req = '1;
    wait_idle();
    check_ok(4'b1111, "R4");

    // all leave, each rejoins at once and must be held off
    rejoin = 1'b1;
    for (int i = 0; i < NPROC; i++) expect_xfer(1, i, "R5");
    for (int i = 0; i < NPROC; i++) expect_xfer(0, i, "R6");
    at_drive(); leave_req = '1;
    wait_idle();
    check_ok(4'b1111, "R6");
    rejoin = 1'b0;
    for (int i = 0; i < NPROC; i++) expect_xfer(1, i, "R5");
    at_drive(); leave_req = '1;
    wait_idle();
    check_ok('0, "R8");

    // round with two participants: 2 then 1
    at_drive(); part_count = CW'(2);
    expect_xfer(0, 2, "R3");
    at_drive(); enter_req[2] = 1'b1;
    wait_idle();
    at_drive(); enter_req[2] = 1'b1;   // repeated entry must be ignored
    repeat (4) @(posedge clk);
    check_ok('0, "R4");
    at_drive(); enter_req[2] = 1'b0;
    expect_xfer(0, 1, "R4");
    at_drive(); enter_req[1] = 1'b1;
    wait_idle();
    check_ok(4'b0110, "R4");

    // outsider exit ignored during release
    at_drive(); leave_req[0] = 1'b1;
    repeat (4) @(posedge clk);
    check_ok(4'b0110, "R7");
    at_drive(); leave_req[0] = 1'b0;
    expect_xfer(1, 1, "R5");
    expect_xfer(1, 2, "R8");
    at_drive(); leave_req = 4'b0110;
    wait_idle();
    check_ok('0, "R8");

    // exit request in gathering phase ignored
    at_drive(); leave_req = 4'b1001;
    repeat (4) @(posedge clk);
    check_ok('0, "R7");
    at_drive(); leave_req = '0;

    // reuse with full count after the small round
    at_drive(); part_count = CW'(NPROC);
    for (int i = NPROC - 1; i >= 0; i--) begin
      expect_xfer(0, i, "R8");
      at_drive(); enter_req[i] = 1'b1;
      wait_idle();
    end
    check_ok(4'b1111, "R8");
    repeat (2) @(posedge clk);
    summary();
  end
endmodule